// File: doc/BRIEF.md
# Receive Break and Idle-Timeout Monitor

This block sits next to a serial receiver and its receive FIFO and turns two line conditions into interrupt flags. It watches each character the receiver delivers. A character whose data bits are all zero and whose stop bit was sampled low is a break character. When a run of consecutive break characters grows longer than a programmed count, the break flag is raised.

In parallel, a bit-time timer measures how long received data has been left unread. It advances on bit-time ticks only while the timeout function is enabled and the FIFO holds data. A software read of the FIFO or a newly received character restarts it. When the timer reaches the programmed limit, the timeout flag is raised.

Both flags are sticky. Software clears each one with a one-cycle clear strobe. The receiver and the FIFO are outside this block: it sees only their strobes and flags.

Top module: `rx_idle_break_mon`

## Requirements
- R1: A character is a break character only when its strobe is high, all of its data bits are 0 and its frame-error flag is 1. An all-zero character without frame error, and a nonzero character with frame error, are not break characters.
- R2: A valid character that is not a break character returns the consecutive-break count to zero. The count saturates rather than wrapping.
- R3: The break flag is set on the clock edge that accepts a break character making the consecutive count strictly greater than the threshold. The flag is visible after that edge. A count equal to the threshold does not set it.
- R4: While running, the timer advances by one on each bit-time tick. The timeout flag is set on the edge of the tick that brings the timer to the limit, and not on the tick before.
- R4 (continued): The timer then stays at the limit and does not fire again until it is restarted. A limit of 0 never fires.
- R5: A FIFO read strobe or a character strobe restarts the timer at zero. A restart takes priority over a tick in the same cycle.
- R6: The timer is held at zero while the timeout enable is 0 or the FIFO is empty.
- R7: Each interrupt flag, once set, stays at 1 until its clear strobe is seen, whatever else happens on the inputs.
- R8: A clear strobe returns its flag to 0 on the next edge. If the flag's set condition occurs in the same cycle, the set wins and the flag stays 1.
- R9: After reset both flags are 0, the break count is zero and the timer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | One-cycle strobe: a character was received |
| char_data_i | input | DATA_W | Data bits of the received character |
| char_frame_err_i | input | 1 | Stop bit of the character was sampled low |
| fifo_nonempty_i | input | 1 | Receive FIFO holds at least one entry |
| fifo_rd_i | input | 1 | One-cycle strobe: software read the FIFO |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| brk_thresh_i | input | CNT_W | Break characters allowed before the flag fires (flag on count > value) |
| tmo_limit_i | input | TMO_W | Timeout limit in bit times (0 disables firing) |
| tmo_en_i | input | 1 | Timeout function enable |
| brk_clr_i | input | 1 | Clear strobe for the break flag |
| tmo_clr_i | input | 1 | Clear strobe for the timeout flag |
| brk_irq_o | output | 1 | Sticky break interrupt flag |
| tmo_irq_o | output | 1 | Sticky timeout interrupt flag |

## Verification
The hardest situation to reach is a timer that has already fired and then saturated at the limit. After a clear, it must stay silent until something restarts it. The stimulus reaches this state on purpose: it fires the timeout, clears the flag, keeps ticking without a read and checks that the flag stays low. It then restarts the timer with a read, and separately with a received character, and checks that the full limit is counted again. Break runs are interrupted by all-zero characters without frame error and by nonzero characters with frame error, to show that only true break characters extend the run.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;
  localparam int unsigned NUM_IRQ = 2;
  typedef enum int unsigned {
    IRQ_BRK = 0,
    IRQ_TMO = 1
  } irq_idx_e;
endpackage

// File: rtl/rxmon_brk_cnt.sv
module rxmon_brk_cnt #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              frame_err_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic              set_o
);
  // one extra bit so the count can always exceed any threshold
  localparam int unsigned CW = CNT_W + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          is_brk;
  logic [CW-1:0] cnt_q, cnt_inc;

  assign is_brk  = valid_i && frame_err_i && (data_i == '0);
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
  assign set_o   = is_brk && (cnt_inc > {1'b0, thresh_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= is_brk ? cnt_inc : '0;
  end

  // R2: a non-break character clears the run
  a_r2_run_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_brk) |=> (cnt_q == '0));
  // R2: count never wraps back to zero on a break character
  a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_brk && cnt_q != '0) |=> (cnt_q != '0));
endmodule

// File: rtl/rxmon_tmo_tmr.sv
module rxmon_tmo_tmr #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             nonempty_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             set_o
);
  logic             run, at_lim;
  logic [TMO_W-1:0] tmr_q, tmr_nxt;

  assign run     = en_i && nonempty_i;
  assign at_lim  = (tmr_q >= limit_i);
  assign tmr_nxt = tmr_q + TMO_W'(1);
  assign set_o   = run && !restart_i && tick_i && !at_lim && (tmr_nxt == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tmr_q <= '0;
    else if (restart_i || !run)    tmr_q <= '0;
    else if (tick_i && !at_lim)    tmr_q <= tmr_nxt;
  end

  // R5: restart wins over tick
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (tmr_q == '0));
  // R6: held while idle
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (tmr_q == '0));
  // R4: firing leaves the timer at the limit
  a_r4_fire_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> (tmr_q == $past(limit_i)));
  // R4: no advance without a tick
  a_r4_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i && run) |=> $stable(tmr_q));
endmodule

// File: rtl/rxmon_sticky.sv
module rxmon_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i || (q_o && !clr_i);
  end

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/rx_idle_break_mon.sv
module rx_idle_break_mon
  import rxmon_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_frame_err_i,
  input  logic              fifo_nonempty_i,
  input  logic              fifo_rd_i,
  input  logic              bit_tick_i,
  input  logic [CNT_W-1:0]  brk_thresh_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              tmo_en_i,
  input  logic              brk_clr_i,
  input  logic              tmo_clr_i,
  output logic              brk_irq_o,
  output logic              tmo_irq_o
);
  logic [NUM_IRQ-1:0] set_vec, clr_vec, irq_vec;

  rxmon_brk_cnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_brk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (char_valid_i),
    .data_i      (char_data_i),
    .frame_err_i (char_frame_err_i),
    .thresh_i    (brk_thresh_i),
    .set_o       (set_vec[IRQ_BRK])
  );

  rxmon_tmo_tmr #(.TMO_W(TMO_W)) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tmo_en_i),
    .nonempty_i (fifo_nonempty_i),
    .restart_i  (char_valid_i || fifo_rd_i),
    .tick_i     (bit_tick_i),
    .limit_i    (tmo_limit_i),
    .set_o      (set_vec[IRQ_TMO])
  );

  assign clr_vec[IRQ_BRK] = brk_clr_i;
  assign clr_vec[IRQ_TMO] = tmo_clr_i;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    rxmon_sticky u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .q_o    (irq_vec[i])
    );
  end

  assign brk_irq_o = irq_vec[IRQ_BRK];
  assign tmo_irq_o = irq_vec[IRQ_TMO];

  // R1: a character without frame error never raises the break flag
  a_r1_needs_frame_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!brk_irq_o && !(char_valid_i && char_frame_err_i)) |=> !brk_irq_o);
  // R4: the timeout flag never rises without a tick
  a_r4_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmo_irq_o && !bit_tick_i) |=> !tmo_irq_o);
endmodule

// File: tb/sim_rx_idle_break_mon.sv
`timescale 1ns/1ps
module sim_rx_idle_break_mon;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned TMO_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_valid = 1'b0;
  logic [DATA_W-1:0] char_data = '0;
  logic char_fe = 1'b0;
  logic nonempty = 1'b0;
  logic rd = 1'b0;
  logic tick = 1'b0;
  logic [CNT_W-1:0] thresh = '0;
  logic [TMO_W-1:0] limit = '0;
  logic tmo_en = 1'b0;
  logic brk_clr = 1'b0;
  logic tmo_clr = 1'b0;
  logic brk_irq, tmo_irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rx_idle_break_mon #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(char_valid), .char_data_i(char_data),
    .char_frame_err_i(char_fe), .fifo_nonempty_i(nonempty), .fifo_rd_i(rd),
    .bit_tick_i(tick), .brk_thresh_i(thresh), .tmo_limit_i(limit), .tmo_en_i(tmo_en),
    .brk_clr_i(brk_clr), .tmo_clr_i(tmo_clr), .brk_irq_o(brk_irq), .tmo_irq_o(tmo_irq)
  );

  typedef struct {
    logic  brk;
    logic  tmo;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;

  // monitor side: pop expectations and compare against the outputs
  function automatic void drain();
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (brk_irq !== e.brk || tmo_irq !== e.tmo) begin
        errors++;
        $display("FAIL %s: brk=%0b tmo=%0b expected brk=%0b tmo=%0b",
                 e.tag, brk_irq, tmo_irq, e.brk, e.tmo);
      end
    end
  endfunction

  initial forever begin
    @(mon_ev);
    drain();
  end

  // driver side
  task automatic expect_irq(input logic b, input logic t, input string tag);
    exp_t e;
    e.brk = b; e.tmo = t; e.tag = tag;
    exp_q.push_back(e);
    -> mon_ev;
    #0.1;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic send_char(input logic [DATA_W-1:0] d, input logic fe);
    char_valid = 1'b1; char_data = d; char_fe = fe;
    cyc();
    char_valid = 1'b0; char_fe = 1'b0; char_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
      tick = 1'b0;
    end
  endtask

  task automatic clr_brk();
    brk_clr = 1'b1; cyc(); brk_clr = 1'b0;
  endtask

  task automatic clr_tmo();
    tmo_clr = 1'b1; cyc(); tmo_clr = 1'b0;
  endtask

  task automatic read_fifo();
    rd = 1'b1; cyc(); rd = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    expect_irq(1'b0, 1'b0, "R9 during reset");
    rst_n = 1'b1;
    cyc();
    expect_irq(1'b0, 1'b0, "R9 after reset");

    // break run, threshold 2: fires on the third
    thresh = 4'd2;
    send_char(8'h00, 1'b1);
    send_char(8'h00, 1'b1);
    expect_irq(1'b0, 1'b0, "R3 count equal to threshold");
    send_char(8'h00, 1'b1);
    expect_irq(1'b1, 1'b0, "R3 count exceeds threshold");
    send_char(8'h41, 1'b0);
    ticks(3);
    expect_irq(1'b1, 1'b0, "R7 break flag sticky");
    clr_brk();
    expect_irq(1'b0, 1'b0, "R8 break clear");

    // R1 / R2: non-break characters break the run
    thresh = 4'd1;
    send_char(8'h00, 1'b1);
    send_char(8'h00, 1'b0);
    send_char(8'h00, 1'b1);
    expect_irq(1'b0, 1'b0, "R1 zero char without frame error resets run");
    send_char(8'h80, 1'b1);
    send_char(8'h00, 1'b1);
    expect_irq(1'b0, 1'b0, "R2 nonzero char with frame error resets run");
    send_char(8'h00, 1'b1);
    expect_irq(1'b1, 1'b0, "R1 two true break chars exceed threshold 1");
    clr_brk();

    // R8: set wins over clear (threshold 0, one break char)
    thresh = 4'd0;
    brk_clr = 1'b1;
    send_char(8'h00, 1'b1);
    brk_clr = 1'b0;
    expect_irq(1'b1, 1'b0, "R8 set wins over clear");
    clr_brk();
    expect_irq(1'b0, 1'b0, "R8 break cleared again");

    // timeout, limit 5
    limit = 16'd5;
    tmo_en = 1'b1;
    nonempty = 1'b1;
    ticks(4);
    expect_irq(1'b0, 1'b0, "R4 one tick before limit");
    ticks(1);
    expect_irq(1'b0, 1'b1, "R4 tick reaching limit");
    ticks(2);
    expect_irq(1'b0, 1'b1, "R7 timeout flag sticky");
    clr_tmo();
    ticks(6);
    expect_irq(1'b0, 1'b0, "R4 saturated timer does not refire");

    // R5: restart by read
    read_fifo();
    ticks(3);
    read_fifo();
    ticks(4);
    expect_irq(1'b0, 1'b0, "R5 read restarts timer");
    ticks(1);
    expect_irq(1'b0, 1'b1, "R5 fires limit ticks after read");
    clr_tmo();

    // R5: restart by received character, same cycle as a tick
    read_fifo();
    ticks(3);
    tick = 1'b1;
    send_char(8'h55, 1'b0);
    tick = 1'b0;
    ticks(4);
    expect_irq(1'b0, 1'b0, "R5 character restarts timer over tick");
    ticks(1);
    expect_irq(1'b0, 1'b1, "R5 fires limit ticks after character");
    clr_tmo();
    expect_irq(1'b0, 1'b0, "R8 timeout clear");

    // R6: held while empty or disabled
    read_fifo();
    ticks(3);
    nonempty = 1'b0;
    ticks(10);
    nonempty = 1'b1;
    ticks(4);
    expect_irq(1'b0, 1'b0, "R6 empty fifo holds timer at zero");
    tmo_en = 1'b0;
    ticks(10);
    tmo_en = 1'b1;
    ticks(4);
    expect_irq(1'b0, 1'b0, "R6 disable holds timer at zero");
    ticks(1);
    expect_irq(1'b0, 1'b1, "R6 counts again once running");
    clr_tmo();

    // R4: limit 0 never fires
    limit = 16'd0;
    read_fifo();
    ticks(20);
    expect_irq(1'b0, 1'b0, "R4 limit zero never fires");

    cyc();
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule